// File: doc/BRIEF.md
# Asynchronous Bus Slave Transfer Handshake

This block is the slave side of an asynchronous, multiplexed 16-bit address/data bus that carries 22-bit addresses. The upper six address bits travel on separate lines that only matter while the address is presented. When the master raises its sync line, the block latches the full address, the I/O-page select and the direction qualifier. It then decodes whether the cycle targets its memory window or its window inside the I/O page. On a match it serves the data phase. For a read it fetches a word from local logic, drives it onto the bus and raises reply. For a write, word or byte, it hands the data and lane enables to local logic and raises reply.

Local logic sees a simple register port: an index, a space bit (memory or I/O), a one-cycle read pulse with data returned one cycle later, and a one-cycle write pulse with data and byte enables. All bus inputs are taken as already synchronous to `clk`. Deskew and transceivers sit outside the block.

The controller has seven states:
- `ST_IDLE` waits for sync and latches the address.
- `ST_ARMED` waits for a data strobe.
- `ST_RFETCH` waits for local read data.
- `ST_RREPLY` and `ST_WREPLY` hold reply.
- `ST_HOLD` waits for sync to drop after a served cycle.
- `ST_IGNORE` waits for sync to drop after an address miss.

The transitions are:
- `ST_IDLE`→`ST_ARMED` when sync is seen.
- `ST_ARMED`→`ST_IDLE` if sync drops.
- `ST_ARMED`→`ST_IGNORE` on a decode miss.
- `ST_ARMED`→`ST_RFETCH` on data-in in a read cycle.
- `ST_ARMED`→`ST_WREPLY` on data-out in a write cycle.
- `ST_RFETCH`→`ST_RREPLY` always.
- `ST_RREPLY`/`ST_WREPLY`→`ST_HOLD` when the strobe drops.
- `ST_HOLD`/`ST_IGNORE`→`ST_IDLE` when sync drops.

Top module: `async_bus_slave`

## Requirements
- R1: After reset, `bus_reply`, `bus_ad_oe`, `loc_rd` and `loc_wr` are all low.
- R2: The 22-bit address `{bus_ahi_in, bus_ad_in}` and `bus_iosel` are latched in the cycle sync is first seen. Later changes on those lines during the same sync period have no effect on the decoded index.
- R3: The cycle is a write if `bus_wrq` is high when sync is first seen, and a read otherwise. A high `bus_wrq` during the data phase of a read cycle causes no local write.
- R4: With `bus_iosel` low, the cycle hits when address bits 21..MEM_WIN_LOG2 equal those of `MEM_BASE`. It then gives `loc_space`=0 and `loc_addr` = address bits MEM_WIN_LOG2-1..1.
- R5: With `bus_iosel` high, only the low 13 address bits are decoded. The cycle hits when bits 12..IO_WIN_LOG2 equal those of `IO_BASE`, giving `loc_space`=1 and `loc_addr` = address bits IO_WIN_LOG2-1..1 (upper bits zero).
- R6: On a decode miss, `bus_reply`, `loc_rd` and `loc_wr` stay low until sync is negated.
- R7: In a hit read cycle, `bus_din` produces a one-cycle `loc_rd`. `bus_reply` and `bus_ad_oe` rise two clocks after `bus_din` is first sampled, with the word read on `bus_ad_out`.
- R8: In a hit write cycle, `bus_dout` with `bus_wrq` low produces a one-cycle `loc_wr`, with `loc_be`=2'b11 and `loc_wdata` = `bus_ad_in`. `bus_reply` rises one clock later.
- R9: A write with `bus_wrq` high during `bus_dout` is a byte write. It gives `loc_be`=2'b01 when latched address bit 0 is 0 and 2'b10 when it is 1.
- R10: `bus_reply` falls in the clock after the strobe is negated. No further reply or local access occurs until sync has been negated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sync | input | 1 | Master sync (address valid, cycle in progress) |
| bus_din | input | 1 | Data-in strobe (read) |
| bus_dout | input | 1 | Data-out strobe (write data valid) |
| bus_wrq | input | 1 | Write qualifier at sync start, byte qualifier during data-out |
| bus_iosel | input | 1 | I/O-page select, sampled with the address |
| bus_ad_in | input | DATA_W | Multiplexed address/data lines, inbound |
| bus_ahi_in | input | HI_W | Extended address bits 21:16 |
| bus_ad_out | output | DATA_W | Read data to drive onto the bus |
| bus_ad_oe | output | 1 | Drive enable for `bus_ad_out` |
| bus_reply | output | 1 | Slave reply |
| loc_addr | output | LOC_W | Local word index |
| loc_space | output | 1 | 0 memory window, 1 I/O window |
| loc_rd | output | 1 | One-cycle local read request |
| loc_rdata | input | DATA_W | Local read data, valid the cycle after `loc_rd` |
| loc_wr | output | 1 | One-cycle local write request |
| loc_wdata | output | DATA_W | Local write data |
| loc_be | output | DATA_W/8 | Local byte enables |

## Verification
The bench builds the block with its defaults: a 32-byte memory window at 0x2A0000 and a 16-byte window at I/O offset 0x1F40. Both windows are small, so their first and last words and the first address past each one fit in a few vectors. Because the memory base has non-zero bits above 15, a change on the extended lines alone turns a hit into a miss. An I/O access whose upper lines are all ones shows that those lines are ignored for the I/O page. A read with the qualifier raised during its data phase, and a strobe re-raised after reply inside one sync period, cover the two meanings of the qualifier and the release ordering.

// File: rtl/abs_pkg.sv
`timescale 1ns/1ps
package abs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_RFETCH,
        ST_RREPLY,
        ST_WREPLY,
        ST_HOLD,
        ST_IGNORE
    } abs_state_t;
endpackage

// File: rtl/abs_addr_decode.sv
`timescale 1ns/1ps
module abs_addr_decode #(
    parameter int          ADDR_W       = 22,
    parameter int          IO_OFS_W     = 13,
    parameter logic [21:0] MEM_BASE     = 22'h2A0000,
    parameter int          MEM_WIN_LOG2 = 5,
    parameter logic [12:0] IO_BASE      = 13'h1F40,
    parameter int          IO_WIN_LOG2  = 4,
    parameter int          LOC_W        = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              iosel,
    output logic              hit,
    output logic              space,
    output logic [LOC_W-1:0]  index
);
    logic mem_hit;
    logic io_hit;

    // Memory window compares every address bit above the window size.
    assign mem_hit = !iosel &&
        (addr[ADDR_W-1:MEM_WIN_LOG2] == MEM_BASE[ADDR_W-1:MEM_WIN_LOG2]);
    // I/O page: only the page offset bits take part.
    assign io_hit  = iosel &&
        (addr[IO_OFS_W-1:IO_WIN_LOG2] == IO_BASE[IO_OFS_W-1:IO_WIN_LOG2]);

    assign hit   = mem_hit || io_hit;
    assign space = iosel;

    always_comb begin
        index = '0;
        if (iosel)
            index[IO_WIN_LOG2-2:0] = addr[IO_WIN_LOG2-1:1];
        else
            index[MEM_WIN_LOG2-2:0] = addr[MEM_WIN_LOG2-1:1];
    end
endmodule

// File: rtl/abs_lane_select.sv
`timescale 1ns/1ps
module abs_lane_select #(
    parameter int DATA_W = 16
) (
    input  logic                                  byte_mode,
    input  logic [$clog2(DATA_W/8)-1:0]           lane,
    output logic [DATA_W/8-1:0]                   be
);
    localparam int LANES = DATA_W / 8;
    localparam int SEL_W = $clog2(LANES);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign be[i] = !byte_mode || (lane == SEL_W'(i));
    end
endmodule

// File: rtl/async_bus_slave.sv
`timescale 1ns/1ps
module async_bus_slave
    import abs_pkg::*;
#(
    parameter int          DATA_W       = 16,
    parameter int          HI_W         = 6,
    parameter logic [21:0] MEM_BASE     = 22'h2A0000,
    parameter int          MEM_WIN_LOG2 = 5,
    parameter logic [12:0] IO_BASE      = 13'h1F40,
    parameter int          IO_WIN_LOG2  = 4,
    localparam int         ADDR_W       = DATA_W + HI_W,
    localparam int         LOC_W        = ((MEM_WIN_LOG2 > IO_WIN_LOG2) ? MEM_WIN_LOG2 : IO_WIN_LOG2) - 1,
    localparam int         BE_W         = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sync,
    input  logic              bus_din,
    input  logic              bus_dout,
    input  logic              bus_wrq,
    input  logic              bus_iosel,
    input  logic [DATA_W-1:0] bus_ad_in,
    input  logic [HI_W-1:0]   bus_ahi_in,
    output logic [DATA_W-1:0] bus_ad_out,
    output logic              bus_ad_oe,
    output logic              bus_reply,
    output logic [LOC_W-1:0]  loc_addr,
    output logic              loc_space,
    output logic              loc_rd,
    input  logic [DATA_W-1:0] loc_rdata,
    output logic              loc_wr,
    output logic [DATA_W-1:0] loc_wdata,
    output logic [BE_W-1:0]   loc_be
);
    localparam int SEL_W = $clog2(BE_W);

    abs_state_t        state, nxt;
    logic [ADDR_W-1:0] addr_q;
    logic              iosel_q;
    logic              write_q;
    logic [DATA_W-1:0] rdata_q;
    logic              dec_hit;

    abs_addr_decode #(
        .ADDR_W(ADDR_W), .IO_OFS_W(13), .MEM_BASE(MEM_BASE),
        .MEM_WIN_LOG2(MEM_WIN_LOG2), .IO_BASE(IO_BASE),
        .IO_WIN_LOG2(IO_WIN_LOG2), .LOC_W(LOC_W)
    ) u_dec (
        .addr(addr_q), .iosel(iosel_q),
        .hit(dec_hit), .space(loc_space), .index(loc_addr)
    );

    abs_lane_select #(.DATA_W(DATA_W)) u_lane (
        .byte_mode(bus_wrq), .lane(addr_q[SEL_W-1:0]), .be(loc_be)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Address phase capture and read data holding
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            iosel_q <= 1'b0;
            write_q <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (state == ST_IDLE && bus_sync) begin
                addr_q  <= {bus_ahi_in, bus_ad_in};
                iosel_q <= bus_iosel;
                write_q <= bus_wrq;
            end
            if (state == ST_RFETCH)
                rdata_q <= loc_rdata;
        end
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (bus_sync) nxt = ST_ARMED;
            ST_ARMED: begin
                if (!bus_sync)                nxt = ST_IDLE;
                else if (!dec_hit)            nxt = ST_IGNORE;
                else if (write_q && bus_dout) nxt = ST_WREPLY;
                else if (!write_q && bus_din) nxt = ST_RFETCH;
            end
            ST_RFETCH: nxt = ST_RREPLY;
            ST_RREPLY: if (!bus_din)  nxt = ST_HOLD;
            ST_WREPLY: if (!bus_dout) nxt = ST_HOLD;
            ST_HOLD:   if (!bus_sync) nxt = ST_IDLE;
            ST_IGNORE: if (!bus_sync) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        loc_rd     = (state == ST_ARMED) && bus_sync && dec_hit && !write_q && bus_din;
        loc_wr     = (state == ST_ARMED) && bus_sync && dec_hit &&  write_q && bus_dout;
        loc_wdata  = bus_ad_in;
        bus_reply  = (state == ST_RREPLY) || (state == ST_WREPLY);
        bus_ad_oe  = (state == ST_RREPLY);
        bus_ad_out = rdata_q;
    end

    // R6
    reply_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reply |-> dec_hit);
    // R10
    reply_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reply && !bus_din && !bus_dout) |=> !bus_reply);
    // R10
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && bus_sync) |=> (!bus_reply && !loc_rd && !loc_wr));
    // R7
    drive_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ad_oe |-> (bus_reply && !write_q));
    // R8
    write_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loc_wr |=> !loc_wr);
    // R7
    read_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loc_rd |=> !loc_rd);
    // R3
    dir_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(loc_rd && loc_wr));
endmodule

// File: tb/sim_async_bus_slave.sv
`timescale 1ns/1ps
module sim_async_bus_slave;
    typedef struct packed {
        logic        wr;
        logic        byt;
        logic        io;
        logic [21:0] addr;
        logic [15:0] data;
        logic        hit;
        logic [1:0]  be;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b0, 22'h2A0004, 16'h1234, 1'b1, 2'b11}, // R8 word write
        '{1'b0, 1'b0, 1'b0, 22'h2A0004, 16'h0000, 1'b1, 2'b00}, // R7 R3 read back
        '{1'b1, 1'b1, 1'b0, 22'h2A0006, 16'hABCD, 1'b1, 2'b01}, // R9 even byte
        '{1'b1, 1'b1, 1'b0, 22'h2A0007, 16'h5566, 1'b1, 2'b10}, // R9 odd byte
        '{1'b0, 1'b0, 1'b0, 22'h2A0006, 16'h0000, 1'b1, 2'b00}, // R9 merged word
        '{1'b1, 1'b0, 1'b1, 22'h3F1F4A, 16'hBEEF, 1'b1, 2'b11}, // R5 upper lines ignored
        '{1'b0, 1'b0, 1'b1, 22'h001F4A, 16'h0000, 1'b1, 2'b00}, // R5 read
        '{1'b0, 1'b0, 1'b1, 22'h2A0004, 16'h0000, 1'b0, 2'b00}, // R6 io miss
        '{1'b1, 1'b0, 1'b0, 22'h2B0004, 16'h9999, 1'b0, 2'b00}, // R4 high bit miss
        '{1'b1, 1'b0, 1'b0, 22'h2A0020, 16'h8888, 1'b0, 2'b00}, // R4 past window
        '{1'b0, 1'b0, 1'b0, 22'h2A001E, 16'h0000, 1'b1, 2'b00}, // R4 last word
        '{1'b1, 1'b1, 1'b1, 22'h001F4F, 16'h7700, 1'b1, 2'b10}, // R9 io odd byte
        '{1'b0, 1'b0, 1'b1, 22'h001F4E, 16'h0000, 1'b1, 2'b00}, // R5 io last word
        '{1'b0, 1'b0, 1'b0, 22'h001F4A, 16'h0000, 1'b0, 2'b00}  // R4 io offset, mem space
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sync = 1'b0, bus_din = 1'b0, bus_dout = 1'b0, bus_wrq = 1'b0, bus_iosel = 1'b0;
    logic [15:0] bus_ad_in = '0;
    logic [5:0]  bus_ahi_in = '0;
    logic [15:0] bus_ad_out;
    logic        bus_ad_oe, bus_reply;
    logic [3:0]  loc_addr;
    logic        loc_space, loc_rd, loc_wr;
    logic [15:0] loc_rdata = '0;
    logic [15:0] loc_wdata;
    logic [1:0]  loc_be;

    int n_chk = 0;
    int n_bad = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    logic [15:0] store [32];
    logic [15:0] expm  [32];

    always #2.5 clk = ~clk;

    async_bus_slave u0 (
        .clk(clk), .rst_n(rst_n), .bus_sync(bus_sync), .bus_din(bus_din),
        .bus_dout(bus_dout), .bus_wrq(bus_wrq), .bus_iosel(bus_iosel),
        .bus_ad_in(bus_ad_in), .bus_ahi_in(bus_ahi_in), .bus_ad_out(bus_ad_out),
        .bus_ad_oe(bus_ad_oe), .bus_reply(bus_reply), .loc_addr(loc_addr),
        .loc_space(loc_space), .loc_rd(loc_rd), .loc_rdata(loc_rdata),
        .loc_wr(loc_wr), .loc_wdata(loc_wdata), .loc_be(loc_be)
    );

    // Local register file model: registered read, byte-enabled write
    always @(posedge clk) begin
        if (loc_wr) begin
            rd_cnt <= rd_cnt;
            wr_cnt <= wr_cnt + 1;
            if (loc_be[0]) store[{loc_space, loc_addr}][7:0]  <= loc_wdata[7:0];
            if (loc_be[1]) store[{loc_space, loc_addr}][15:8] <= loc_wdata[15:8];
        end
        if (loc_rd) begin
            rd_cnt <= rd_cnt + 1;
            loc_rdata <= store[{loc_space, loc_addr}];
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int eidx(input logic io, input logic [21:0] a);
        if (io) return 16 + int'(a[3:1]);
        return int'(a[4:1]);
    endfunction

    task automatic run_vec(input vec_t v);
        int rd0, wr0, seen, idx;
        rd0 = rd_cnt; wr0 = wr_cnt; seen = -1;
        idx = eidx(v.io, v.addr);
        @(negedge clk);
        bus_ad_in = v.addr[15:0]; bus_ahi_in = v.addr[21:16];
        bus_iosel = v.io; bus_wrq = v.wr; bus_sync = 1'b1;
        @(negedge clk);
        // data phase: extended lines and select released (R2)
        bus_ahi_in = '0; bus_iosel = 1'b0;
        bus_ad_in = v.wr ? v.data : 16'hFFFF;
        bus_wrq = v.wr ? v.byt : 1'b1;  // R3: qualifier high during a read
        bus_dout = v.wr; bus_din = !v.wr;
        #1;
        if (v.hit) begin
            chk({loc_space, loc_addr} == 5'(idx), "R2", "latched index",
                32'({loc_space, loc_addr}), 32'(idx));
            if (v.wr) begin
                chk(loc_wr == 1'b1, "R8", "write pulse", 32'(loc_wr), 1);
                chk(loc_be == v.be, "R9", "byte enables", 32'(loc_be), 32'(v.be));
                chk(loc_wdata == v.data, "R8", "write data", 32'(loc_wdata), 32'(v.data));
            end else begin
                chk(loc_rd == 1'b1 && loc_wr == 1'b0, "R7", "read pulse only",
                    32'({loc_rd, loc_wr}), 32'b10);
            end
        end
        for (int i = 1; i <= 5; i++) begin
            @(negedge clk);
            if (bus_reply && seen < 0) seen = i;
        end
        if (v.hit) begin
            if (v.wr) begin
                chk(seen == 1, "R8", "reply latency", 32'(seen), 1);
                chk(wr_cnt == wr0 + 1 && rd_cnt == rd0, "R8", "one write",
                    32'(wr_cnt - wr0), 1);
                if (v.be[0]) expm[idx][7:0]  = v.data[7:0];
                if (v.be[1]) expm[idx][15:8] = v.data[15:8];
            end else begin
                chk(seen == 2, "R7", "reply latency", 32'(seen), 2);
                chk(bus_ad_oe == 1'b1, "R7", "drive enable", 32'(bus_ad_oe), 1);
                chk(bus_ad_out == expm[idx], "R7", "read data", 32'(bus_ad_out), 32'(expm[idx]));
                chk(wr_cnt == wr0 && rd_cnt == rd0 + 1, "R3", "read stays read",
                    32'(wr_cnt - wr0), 0);
            end
        end else begin
            chk(seen == -1, "R6", "no reply on miss", 32'(seen), 32'hFFFFFFFF);
            chk(wr_cnt == wr0 && rd_cnt == rd0, "R6", "no local access",
                32'((wr_cnt - wr0) + (rd_cnt - rd0)), 0);
        end
        bus_din = 1'b0; bus_dout = 1'b0; bus_wrq = 1'b0;
        @(negedge clk);
        chk(bus_reply == 1'b0, "R10", "reply release", 32'(bus_reply), 0);
        bus_sync = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin
            store[i] = '0;
            expm[i]  = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({bus_reply, bus_ad_oe, loc_rd, loc_wr} == 4'b0, "R1", "reset outputs",
            32'({bus_reply, bus_ad_oe, loc_rd, loc_wr}), 0);

        for (int n = 0; n < NV; n++) run_vec(VECS[n]);

        // R10 directed: long strobe, then strobe re-raised inside the same sync
        begin
            int rd0;
            @(negedge clk);
            bus_ad_in = 16'h0004; bus_ahi_in = 6'h2A; bus_wrq = 1'b0; bus_sync = 1'b1;
            @(negedge clk);
            bus_ahi_in = '0; bus_din = 1'b1;
            repeat (5) @(negedge clk);
            chk(bus_reply == 1'b1 && bus_ad_out == 16'h1234, "R10", "reply held with strobe",
                32'({bus_reply, bus_ad_out}), 32'h11234);
            bus_din = 1'b0;
            @(negedge clk);
            chk(bus_reply == 1'b0, "R10", "reply falls after strobe", 32'(bus_reply), 0);
            rd0 = rd_cnt;
            bus_din = 1'b1;
            repeat (4) @(negedge clk);
            chk(bus_reply == 1'b0 && rd_cnt == rd0, "R10", "no new cycle before sync drop",
                32'({bus_reply, 8'(rd_cnt - rd0)}), 0);
            bus_din = 1'b0; bus_sync = 1'b0;
            @(negedge clk);
        end
        // cycle after the directed test still served
        run_vec(VECS[1]);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule